// File: doc/BRIEF.md
# Two-Wire Bus Event Interrupt Unit

This unit sits beside the bit-level engine of a two-wire serial bus controller and turns the engine's one-cycle event pulses into a single level interrupt request for a host processor. Six kinds of bus event are tracked: a match on the own address, a bus error, a negative acknowledge after a transmitted byte, the acknowledge point of a transferred byte, a completed start while acting as master, and a stop seen while acting as slave. Each event is latched into a sticky status bit that the host clears by writing ones.

A global interrupt enable gates the request. Two of the sources also need qualifier bits of their own: the address match and the master start reach the request line only when their qualifier is set. A core enable bit in a separate mode register clears the status and control registers and holds them at zero while it is low. The host reaches these registers through a small single-cycle write port with a combinational read path on the same address.

Top module: `twb_irq_unit`

## Requirements
- R1: After reset `irq_o` is 0 and every register address (0 mode, 1 control, 2 status, 3 unused) reads 0.
- R2: With the core enabled (mode bit 0 = 1), an event pulse sets its sticky status bit at the next clock edge; the status bit positions are 0 address match, 1 bus error, 2 negative acknowledge, 3 byte done, 4 master start, 5 slave stop.
- R3: A write to address 2 clears each status bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R4: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: While control bit 0 (global interrupt enable) is 0, `irq_o` stays 0 whatever status bits are set.
- R6: A set address-match status bit drives the request only when control bit 1 (match qualifier) is also 1.
- R7: Bus error, negative acknowledge, byte done and slave stop status bits drive the request with the global enable alone.
- R8: A start event is recorded only while `master_i` is 1, and its status bit drives the request only when control bit 2 (start qualifier) is 1.
- R9: A stop event is recorded only while `master_i` is 0.
- R10: While mode bit 0 is 0, status and control read 0 and writes to them have no effect; clearing the bit empties both at the next edge.
- R11: `irq_o` is registered: it rises one clock edge after a qualified status bit is set and stays high while any qualified bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_match_i | input | 1 | Own-address match pulse |
| ev_berr_i | input | 1 | Bus error pulse |
| ev_nack_i | input | 1 | Negative acknowledge after a sent byte |
| ev_done_i | input | 1 | Byte acknowledge point pulse |
| ev_start_i | input | 1 | Start completed pulse |
| ev_stop_i | input | 1 | Stop condition detected pulse |
| master_i | input | 1 | 1 while the controller acts as bus master |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | Level interrupt request |

## Verification
A status bit changes at the first clock edge after its event or clear is sampled, and the read path shows it right after that edge; `irq_o` follows one edge later because it is computed from the registered status and control. The bench drives every input on the falling edge, advances its reference model at the rising edge from the values held before that edge, and compares `rdata_o` and `irq_o` a nanosecond later, so each result is read in the cycle its register chain makes it due. Directed steps reach each corner named above, and a seeded random phase mixes events, clears, control writes and core disables.

// File: rtl/twb_irq_pkg.sv
package twb_irq_pkg;
  localparam int NEVT   = 6;
  localparam int CTL_W  = 3;
  localparam int ADDR_W = 2;

  // status bit positions
  localparam int EV_MATCH = 0;
  localparam int EV_BERR  = 1;
  localparam int EV_NACK  = 2;
  localparam int EV_DONE  = 3;
  localparam int EV_START = 4;
  localparam int EV_STOP  = 5;

  // control bit positions
  localparam int C_IRQEN  = 0;
  localparam int C_MQUAL  = 1;
  localparam int C_SQUAL  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE = 2'd0,
    A_CTL  = 2'd1,
    A_STAT = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/twb_irq_regs.sv
module twb_irq_regs
  import twb_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic              core_en,
  output logic [CTL_W-1:0]  ctl
);
  logic             core_q, core_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             mode_we, ctl_we;

  always_comb begin
    mode_we = wr_en && (addr == A_MODE);
    ctl_we  = wr_en && (addr == A_CTL);
    core_d  = mode_we ? wdata[0] : core_q;
    if (!core_q)
      ctl_d = '0;
    else if (ctl_we)
      ctl_d = wdata[CTL_W-1:0];
    else
      ctl_d = ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= 1'b0;
      ctl_q  <= '0;
    end else begin
      core_q <= core_d;
      ctl_q  <= ctl_d;
    end
  end

  assign core_en = core_q;
  assign ctl     = ctl_q;
endmodule

// File: rtl/twb_irq_flags.sv
module twb_irq_flags
  import twb_irq_pkg::*;
#(
  parameter int N = NEVT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         core_en,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q, flag_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      if (!core_en)
        flag_d[i] = 1'b0;
      else if (set_vec[i])
        flag_d[i] = 1'b1;
      else if (clr_vec[i])
        flag_d[i] = 1'b0;
      else
        flag_d[i] = flag_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/twb_irq_gate.sv
module twb_irq_gate
  import twb_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEVT-1:0]  flags,
  input  logic [CTL_W-1:0] ctl,
  output logic             irq
);
  logic [NEVT-1:0] qual;
  logic            irq_q, irq_d;

  always_comb begin
    qual           = {NEVT{ctl[C_IRQEN]}};
    qual[EV_MATCH] = ctl[C_IRQEN] & ctl[C_MQUAL];
    qual[EV_START] = ctl[C_IRQEN] & ctl[C_SQUAL];
    irq_d          = |(flags & qual);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/twb_irq_unit.sv
module twb_irq_unit
  import twb_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_match_i,
  input  logic              ev_berr_i,
  input  logic              ev_nack_i,
  input  logic              ev_done_i,
  input  logic              ev_start_i,
  input  logic              ev_stop_i,
  input  logic              master_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             core_en;
  logic [CTL_W-1:0] ctl;
  logic [NEVT-1:0]  set_vec, clr_vec, flags;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    set_vec           = '0;
    set_vec[EV_MATCH] = ev_match_i;
    set_vec[EV_BERR]  = ev_berr_i;
    set_vec[EV_NACK]  = ev_nack_i;
    set_vec[EV_DONE]  = ev_done_i;
    set_vec[EV_START] = ev_start_i & master_i;
    set_vec[EV_STOP]  = ev_stop_i & ~master_i;
    clr_vec = (wr_en_i && addr_i == A_STAT) ? wdata_i[NEVT-1:0] : '0;
  end

  twb_irq_regs #(.DW(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en_i),
    .addr    (addr_i),
    .wdata   (wdata_i),
    .core_en (core_en),
    .ctl     (ctl)
  );

  twb_irq_flags #(.N(NEVT)) u_flags (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .core_en (core_en),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags)
  );

  twb_irq_gate u_gate (
    .clk   (clk),
    .rst_n (rst_int_n),
    .flags (flags),
    .ctl   (ctl),
    .irq   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_MODE:  rdata_o[0]          = core_en;
      A_CTL:   rdata_o[CTL_W-1:0]  = ctl;
      A_STAT:  rdata_o[NEVT-1:0]   = flags;
      default: rdata_o             = '0;
    endcase
  end
endmodule

// File: rtl/twb_irq_unit_chk.sv
module twb_irq_unit_chk
  import twb_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_int_n,
  input logic             core_en,
  input logic [CTL_W-1:0] ctl,
  input logic [NEVT-1:0]  flags,
  input logic             ev_berr_i,
  input logic             ev_start_i,
  input logic             master_i,
  input logic             irq_o
);
  // R2
  berr_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (core_en && ev_berr_i) |=> flags[EV_BERR]);

  // R5
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctl[C_IRQEN] |=> !irq_o);

  // R10
  disable_empties_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !core_en |=> (flags == '0 && ctl == '0));

  // R8
  slave_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (core_en && ev_start_i && !master_i && !flags[EV_START]) |=> !flags[EV_START]);

  // R11
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(irq_o) |-> $past(flags != '0));
endmodule

bind twb_irq_unit twb_irq_unit_chk u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .core_en   (core_en),
  .ctl       (ctl),
  .flags     (flags),
  .ev_berr_i (ev_berr_i),
  .ev_start_i(ev_start_i),
  .master_i  (master_i),
  .irq_o     (irq_o)
);

// File: tb/twb_irq_unit_bench.sv
`timescale 1ns/1ps
module twb_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ev = '0;
  logic       master = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model
  logic       m_core = 1'b0;
  logic [2:0] m_ctl  = '0;
  logic [5:0] m_stat = '0;
  logic       m_irq  = 1'b0;

  always #2.5 clk = ~clk;

  twb_irq_unit u_twb_irq_unit (
    .clk(clk), .rst_n(rst_n),
    .ev_match_i(ev[0]), .ev_berr_i(ev[1]), .ev_nack_i(ev[2]),
    .ev_done_i(ev[3]), .ev_start_i(ev[4]), .ev_stop_i(ev[5]),
    .master_i(master), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [5:0] qual_mask(input logic [2:0] c);
    logic [5:0] q;
    q    = {6{c[0]}};
    q[0] = c[0] & c[1];
    q[4] = c[0] & c[2];
    return q;
  endfunction

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0:    return {7'd0, m_core};
      2'd1:    return {5'd0, m_ctl};
      2'd2:    return {2'd0, m_stat};
      default: return 8'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [5:0] e, input logic m,
                      input logic w, input logic [1:0] a, input logic [7:0] d);
    logic [5:0] setv;
    logic [5:0] clrv;
    logic       irq_n;
    logic [5:0] stat_n;
    logic [2:0] ctl_n;
    logic       core_n;
    @(negedge clk);
    ev = e; master = m; we = w; addr = a; wdata = d;
    @(posedge clk);
    setv    = e;
    setv[4] = e[4] & m;
    setv[5] = e[5] & ~m;
    clrv    = (w && a == 2'd2) ? d[5:0] : 6'd0;
    irq_n   = |(m_stat & qual_mask(m_ctl));
    stat_n  = m_core ? ((m_stat & ~clrv) | setv) : 6'd0;
    ctl_n   = !m_core ? 3'd0 : ((w && a == 2'd1) ? d[2:0] : m_ctl);
    core_n  = (w && a == 2'd0) ? d[0] : m_core;
    m_irq = irq_n; m_stat = stat_n; m_ctl = ctl_n; m_core = core_n;
    #1;
    check({tag, " irq"}, {7'd0, irq}, {7'd0, m_irq});
    check({tag, " rdata"}, rdata, model_read(a));
  endtask

  task automatic idle(input string tag, input logic [1:0] a);
    step(tag, 6'd0, 1'b0, 1'b0, a, 8'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq in reset", {7'd0, irq}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) idle("R1 settle", 2'd2);
    for (int a = 0; a < 4; a++) idle("R1 reset read", a[1:0]);

    // enable core and global interrupt
    step("R10 enable core", 6'd0, 1'b0, 1'b1, 2'd0, 8'h01);
    step("R7 irq enable", 6'd0, 1'b0, 1'b1, 2'd1, 8'h01);

    // bus error sets flag, then irq
    step("R2 berr event", 6'b000010, 1'b0, 1'b0, 2'd2, 8'd0);
    idle("R11 irq rises", 2'd2);
    idle("R11 irq holds", 2'd2);
    step("R3 clear berr", 6'd0, 1'b0, 1'b1, 2'd2, 8'h02);
    idle("R11 irq falls", 2'd2);

    // nack, done; clear only one
    step("R7 nack+done", 6'b001100, 1'b0, 1'b0, 2'd2, 8'd0);
    idle("R7 irq", 2'd2);
    step("R3 partial clear", 6'd0, 1'b0, 1'b1, 2'd2, 8'h04);
    idle("R11 still high", 2'd2);
    step("R3 clear done", 6'd0, 1'b0, 1'b1, 2'd2, 8'h08);
    idle("R3 empty", 2'd2);

    // set beats clear
    step("R4 set vs clear", 6'b001000, 1'b0, 1'b1, 2'd2, 8'h08);
    idle("R4 irq", 2'd2);
    step("R4 cleanup", 6'd0, 1'b0, 1'b1, 2'd2, 8'h3f);

    // match without then with qualifier
    step("R6 match event", 6'b000001, 1'b0, 1'b0, 2'd2, 8'd0);
    idle("R6 unqualified", 2'd2);
    idle("R6 unqualified hold", 2'd2);
    step("R6 set qualifier", 6'd0, 1'b0, 1'b1, 2'd1, 8'h03);
    idle("R6 qualified", 2'd2);
    idle("R6 irq", 2'd2);
    step("R6 cleanup", 6'd0, 1'b0, 1'b1, 2'd2, 8'h3f);

    // start: slave ignored, master recorded, qualifier
    step("R8 start as slave", 6'b010000, 1'b0, 1'b0, 2'd2, 8'd0);
    idle("R8 slave start ignored", 2'd2);
    step("R8 start as master", 6'b010000, 1'b1, 1'b0, 2'd2, 8'd0);
    idle("R8 no start qual", 2'd2);
    step("R8 start qual", 6'd0, 1'b0, 1'b1, 2'd1, 8'h05);
    idle("R8 qualified", 2'd2);
    idle("R8 irq", 2'd2);
    step("R8 cleanup", 6'd0, 1'b0, 1'b1, 2'd2, 8'h3f);

    // stop: master ignored, slave recorded
    step("R9 stop as master", 6'b100000, 1'b1, 1'b0, 2'd2, 8'd0);
    idle("R9 master stop ignored", 2'd2);
    step("R9 stop as slave", 6'b100000, 1'b0, 1'b0, 2'd2, 8'd0);
    idle("R9 irq", 2'd2);

    // global enable off
    step("R5 irq enable off", 6'b001110, 1'b0, 1'b1, 2'd1, 8'h06);
    idle("R5 low", 2'd2);
    idle("R5 still low", 2'd2);

    // core disable
    step("R10 core off", 6'd0, 1'b0, 1'b1, 2'd0, 8'h00);
    idle("R10 status cleared", 2'd2);
    idle("R10 ctl cleared", 2'd1);
    step("R10 ctl write ignored", 6'd0, 1'b0, 1'b1, 2'd1, 8'h07);
    step("R10 event ignored", 6'b111111, 1'b0, 1'b0, 2'd2, 8'd0);
    idle("R10 status empty", 2'd2);
    step("R10 core on", 6'd0, 1'b0, 1'b1, 2'd0, 8'h01);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] e;
      logic       w;
      logic [1:0] a;
      logic [7:0] d;
      e = 6'($urandom) & 6'($urandom) & 6'($urandom);
      w = ($urandom % 4) == 0;
      a = 2'($urandom);
      d = 8'($urandom);
      if (w && a == 2'd0) d[0] = ($urandom % 16) != 0;
      step("R11 random", e, 1'($urandom), w, a, d);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule